// File: doc/BRIEF.md
# Escape-Time Fractal Iteration Unit

This block performs one step of the escape-time recurrence z ← z² + c on a single token. A token carries the point under test c, the running value z, an iteration count and a flag that records whether the orbit has already left the bounded region. The unit is meant to be one link in a long series chain. Each unit hands its updated token straight to the next one, so a chain of N units applies N iterations, and a new token can enter on every clock.

The work is split over two register stages. The first stage forms the three products zr², zi² and zr·zi with three inferred multipliers. The second stage tests for escape, rescales the products, adds c and updates the count and flag. All fixed-point values are signed two's complement with a sign bit, one integer bit and twelve fraction bits. A raw value v stands for v/4096, so the range is [-2, 2). Tokens that have escaped pass through the unit frozen.

Top module: `mandel_iter_unit`

## Requirements
- R1: For a valid token with the escaped flag clear that does not escape, out_zr equals floor((zr² − zi²)/4096) + cr, computed on the raw signed values (arithmetic right shift of 12).
- R2: Under the same condition, out_zi equals floor(2·zr·zi/4096) + ci on raw values.
- R3: out_vld equals in_vld delayed by exactly two clocks. A token may enter on every cycle, and a cycle with in_vld low gives a cycle with out_vld low.
- R4: If the escaped flag is clear and zr² + zi² is strictly greater than 4 (raw product sum above 4·2^24), out_esc is 1 and out_zr/out_zi equal the incoming z.
- R5: If the escaped flag is clear and either new component falls outside the raw range [-8192, 8191], out_esc is 1 and z is forwarded unchanged.
- R6: If the incoming escaped flag is clear, out_cnt is in_cnt + 1 whether or not the token escapes on this pass. It saturates at all ones (255 with 8 bits).
- R7: If the incoming escaped flag is 1, out_esc is 1 and out_zr, out_zi and out_cnt equal their inputs.
- R8: out_cr and out_ci always equal the cr and ci that entered with the same token.
- R9: While rst is high, and on the two cycles after it falls until new tokens arrive, out_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input token valid |
| in_cr | input | 14 | Real part of c, signed raw |
| in_ci | input | 14 | Imaginary part of c, signed raw |
| in_zr | input | 14 | Real part of z, signed raw |
| in_zi | input | 14 | Imaginary part of z, signed raw |
| in_cnt | input | 8 | Iteration count |
| in_esc | input | 1 | Escaped flag |
| out_vld | output | 1 | Output token valid |
| out_cr | output | 14 | Forwarded real part of c |
| out_ci | output | 14 | Forwarded imaginary part of c |
| out_zr | output | 14 | Updated real part of z |
| out_zi | output | 14 | Updated imaginary part of z |
| out_cnt | output | 8 | Updated iteration count |
| out_esc | output | 1 | Updated escaped flag |

## Verification
The hardest case to reach is an escape caused only by overflow of the new z while |z|² is still at or below 4. A plain chain starting from z = 0 reaches that case only after several iterations, and only for a few points. A second hard case is the counter sitting at its saturation value. Because the unit stands alone, the bench drives z and the count directly. It sweeps a 1/8-step grid over the whole z plane for two fixed values of c, and then runs a pseudo-random phase whose counts are biased towards 254 and 255, with random bubbles and pre-escaped tokens.

// File: rtl/mandel_pkg.sv
package mandel_pkg;
  localparam int DEF_INT_W  = 1;
  localparam int DEF_FRAC_W = 12;
  localparam int DEF_CNT_W  = 8;
endpackage

// File: rtl/mandel_square.sv
module mandel_square #(
  parameter int W     = 14,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [W-1:0]  in_cr,
  input  logic signed [W-1:0]  in_ci,
  input  logic signed [W-1:0]  in_zr,
  input  logic signed [W-1:0]  in_zi,
  input  logic [CNT_W-1:0]     in_cnt,
  input  logic                 in_esc,
  output logic                 s_vld,
  output logic signed [W-1:0]  s_cr,
  output logic signed [W-1:0]  s_ci,
  output logic signed [W-1:0]  s_zr,
  output logic signed [W-1:0]  s_zi,
  output logic signed [2*W-1:0] s_xx,
  output logic signed [2*W-1:0] s_yy,
  output logic signed [2*W-1:0] s_xy,
  output logic [CNT_W-1:0]     s_cnt,
  output logic                 s_esc
);
  localparam int P = 2 * W;

  logic signed [P-1:0] ezr, ezi;
  assign ezr = P'(in_zr);
  assign ezi = P'(in_zi);

  // Stage 1: the three products of the complex square, full width.
  always_ff @(posedge clk) begin
    if (rst) s_vld <= 1'b0;
    else     s_vld <= in_vld;
    s_xx  <= ezr * ezr;
    s_yy  <= ezi * ezi;
    s_xy  <= ezr * ezi;
    s_cr  <= in_cr;
    s_ci  <= in_ci;
    s_zr  <= in_zr;
    s_zi  <= in_zi;
    s_cnt <= in_cnt;
    s_esc <= in_esc;
  end

  a_r3_vld_follow: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> s_vld);
  a_r3_bubble_follow: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !s_vld);
  a_r7_esc_sticky: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_esc) |=> s_esc);
endmodule

// File: rtl/mandel_escape.sv
module mandel_escape #(
  parameter int W      = 14,
  parameter int FRAC_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_vld,
  input  logic signed [W-1:0]   s_cr,
  input  logic signed [W-1:0]   s_ci,
  input  logic signed [W-1:0]   s_zr,
  input  logic signed [W-1:0]   s_zi,
  input  logic signed [2*W-1:0] s_xx,
  input  logic signed [2*W-1:0] s_yy,
  input  logic signed [2*W-1:0] s_xy,
  input  logic [CNT_W-1:0]      s_cnt,
  input  logic                  s_esc,
  output logic                  out_vld,
  output logic signed [W-1:0]   out_cr,
  output logic signed [W-1:0]   out_ci,
  output logic signed [W-1:0]   out_zr,
  output logic signed [W-1:0]   out_zi,
  output logic [CNT_W-1:0]      out_cnt,
  output logic                  out_esc
);
  localparam int P = 2 * W;
  // Radius-squared limit 4, expressed in product scale (2*FRAC_W fraction bits).
  localparam logic signed [P:0]   MAG_LIM = (P+1)'(4) <<< (2 * FRAC_W);
  localparam logic signed [P+1:0] Z_MAX   = (P+2)'((2 ** (W-1)) - 1);
  localparam logic signed [P+1:0] Z_MIN   = (P+2)'(-(2 ** (W-1)));

  logic signed [P:0]   mag, diff, twoxy;
  logic signed [P+1:0] nr_w, ni_w;
  logic                too_big, ovf, hold;
  logic [CNT_W-1:0]    cnt_nx;

  always_comb begin
    mag     = (P+1)'(s_xx) + (P+1)'(s_yy);
    diff    = (P+1)'(s_xx) - (P+1)'(s_yy);
    twoxy   = (P+1)'(s_xy) <<< 1;
    nr_w    = (P+2)'(diff >>> FRAC_W) + (P+2)'(s_cr);
    ni_w    = (P+2)'(twoxy >>> FRAC_W) + (P+2)'(s_ci);
    too_big = mag > MAG_LIM;
    ovf     = (nr_w > Z_MAX) || (nr_w < Z_MIN) || (ni_w > Z_MAX) || (ni_w < Z_MIN);
    hold    = s_esc || too_big || ovf;
    cnt_nx  = (&s_cnt) ? s_cnt : s_cnt + CNT_W'(1);
  end

  // Stage 2: escape decision and token update.
  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= s_vld;
    out_cr  <= s_cr;
    out_ci  <= s_ci;
    out_esc <= hold;
    out_cnt <= s_esc ? s_cnt : cnt_nx;
    out_zr  <= hold ? s_zr : nr_w[W-1:0];
    out_zi  <= hold ? s_zi : ni_w[W-1:0];
  end

  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    (s_vld && s_esc) |=> (out_esc && out_zr == $past(s_zr) &&
                          out_zi == $past(s_zi) && out_cnt == $past(s_cnt)));
  a_r6_count: assert property (@(posedge clk) disable iff (rst)
    (s_vld && !s_esc && !(&s_cnt)) |=> (out_cnt == CNT_W'($past(s_cnt) + CNT_W'(1))));
  a_r8_c_carry: assert property (@(posedge clk) disable iff (rst)
    s_vld |=> (out_cr == $past(s_cr) && out_ci == $past(s_ci)));
  a_r4_mag_escape: assert property (@(posedge clk) disable iff (rst)
    (s_vld && too_big) |=> (out_esc && out_zr == $past(s_zr)));
endmodule

// File: rtl/mandel_iter_unit.sv
module mandel_iter_unit
  import mandel_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int CNT_W  = DEF_CNT_W,
  localparam int W     = 1 + INT_W + FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [W-1:0]  in_cr,
  input  logic signed [W-1:0]  in_ci,
  input  logic signed [W-1:0]  in_zr,
  input  logic signed [W-1:0]  in_zi,
  input  logic [CNT_W-1:0]     in_cnt,
  input  logic                 in_esc,
  output logic                 out_vld,
  output logic signed [W-1:0]  out_cr,
  output logic signed [W-1:0]  out_ci,
  output logic signed [W-1:0]  out_zr,
  output logic signed [W-1:0]  out_zi,
  output logic [CNT_W-1:0]     out_cnt,
  output logic                 out_esc
);
  localparam int P = 2 * W;

  logic                s_vld, s_esc;
  logic signed [W-1:0] s_cr, s_ci, s_zr, s_zi;
  logic signed [P-1:0] s_xx, s_yy, s_xy;
  logic [CNT_W-1:0]    s_cnt;

  mandel_square #(.W(W), .CNT_W(CNT_W)) u_square (
    .clk(clk), .rst(rst),
    .in_vld(in_vld), .in_cr(in_cr), .in_ci(in_ci), .in_zr(in_zr), .in_zi(in_zi),
    .in_cnt(in_cnt), .in_esc(in_esc),
    .s_vld(s_vld), .s_cr(s_cr), .s_ci(s_ci), .s_zr(s_zr), .s_zi(s_zi),
    .s_xx(s_xx), .s_yy(s_yy), .s_xy(s_xy), .s_cnt(s_cnt), .s_esc(s_esc)
  );

  mandel_escape #(.W(W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_escape (
    .clk(clk), .rst(rst),
    .s_vld(s_vld), .s_cr(s_cr), .s_ci(s_ci), .s_zr(s_zr), .s_zi(s_zi),
    .s_xx(s_xx), .s_yy(s_yy), .s_xy(s_xy), .s_cnt(s_cnt), .s_esc(s_esc),
    .out_vld(out_vld), .out_cr(out_cr), .out_ci(out_ci), .out_zr(out_zr),
    .out_zi(out_zi), .out_cnt(out_cnt), .out_esc(out_esc)
  );

  a_r9_reset_idle: assert property (@(posedge clk) rst |=> !out_vld);
endmodule

// File: tb/tb_mandel_iter_unit.sv
module tb_mandel_iter_unit;
  localparam int W = 14;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_vld, in_esc, out_vld, out_esc;
  logic signed [W-1:0] in_cr, in_ci, in_zr, in_zi, out_cr, out_ci, out_zr, out_zi;
  logic [CNT_W-1:0] in_cnt, out_cnt;

  mandel_iter_unit dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_cr(in_cr), .in_ci(in_ci),
    .in_zr(in_zr), .in_zi(in_zi), .in_cnt(in_cnt), .in_esc(in_esc),
    .out_vld(out_vld), .out_cr(out_cr), .out_ci(out_ci), .out_zr(out_zr),
    .out_zi(out_zi), .out_cnt(out_cnt), .out_esc(out_esc)
  );

  int checks = 0, fails = 0, nstep = 0;
  bit reported = 0;
  int unsigned seed = 32'h1234_5678;

  bit     e_vld[4], e_esc[4];
  longint e_cr[4], e_ci[4], e_zr[4], e_zi[4], e_cnt[4];
  string  e_tz[4], e_tc[4];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic int rsigned();
    return int'((rnd() >> 8) % 16384) - 8192;
  endfunction

  // One cycle: check the token issued two steps earlier, then drive a new one.
  task automatic step(input bit v, input int cr, input int ci, input int zr,
                      input int zi, input int cnt, input bit esc);
    longint x2, y2, xy, nr, ni;
    bit big, ov;
    int j, k;
    @(negedge clk);
    if (nstep >= 2) begin
      j = (nstep - 2) % 4;
      chk("R3 out_vld", longint'(out_vld), longint'(e_vld[j]));
      if (e_vld[j]) begin
        chk({e_tz[j], " out_zr"}, longint'(out_zr), e_zr[j]);
        chk({e_tz[j], " out_zi"}, longint'(out_zi), e_zi[j]);
        chk({e_tz[j], " out_esc"}, longint'(out_esc), longint'(e_esc[j]));
        chk({e_tc[j], " out_cnt"}, longint'(out_cnt), e_cnt[j]);
        chk("R8 out_cr", longint'(out_cr), e_cr[j]);
        chk("R8 out_ci", longint'(out_ci), e_ci[j]);
      end
    end
    in_vld = v;
    in_cr  = W'(cr);
    in_ci  = W'(ci);
    in_zr  = W'(zr);
    in_zi  = W'(zi);
    in_cnt = CNT_W'(cnt);
    in_esc = esc;
    k = nstep % 4;
    x2  = longint'(zr) * longint'(zr);
    y2  = longint'(zi) * longint'(zi);
    xy  = longint'(zr) * longint'(zi);
    nr  = ((x2 - y2) >>> 12) + cr;
    ni  = ((2 * xy) >>> 12) + ci;
    big = (x2 + y2) > (longint'(4) << 24);
    ov  = (nr > 8191) || (nr < -8192) || (ni > 8191) || (ni < -8192);
    e_vld[k] = v;
    e_cr[k]  = cr;
    e_ci[k]  = ci;
    if (esc) begin
      e_zr[k] = zr; e_zi[k] = zi; e_esc[k] = 1; e_cnt[k] = cnt;
      e_tz[k] = "R7"; e_tc[k] = "R7";
    end else begin
      e_cnt[k] = (cnt == 255) ? 255 : cnt + 1;
      e_tc[k]  = "R6";
      if (big || ov) begin
        e_zr[k] = zr; e_zi[k] = zi; e_esc[k] = 1;
        e_tz[k] = big ? "R4" : "R5";
      end else begin
        e_zr[k] = nr; e_zi[k] = ni; e_esc[k] = 0;
        e_tz[k] = "R1";
      end
    end
    nstep++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; in_vld = 0; in_cr = '0; in_ci = '0; in_zr = '0; in_zi = '0;
    in_cnt = '0; in_esc = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset out_vld", longint'(out_vld), 0);
    rst = 0;
    @(negedge clk);
    chk("R9 idle after reset", longint'(out_vld), 0);

    // c grid with z = 0 (R1, R2, R8)
    for (int a = -8192; a < 8192; a += 512)
      for (int b = -8192; b < 8192; b += 512)
        step(1, a, b, 0, 0, 0, 0);

    // z grid over the whole plane, two fixed c values (R4, R5)
    for (int a = -8192; a < 8192; a += 512)
      for (int b = -8192; b < 8192; b += 512) begin
        step(1, 0, 0, a, b, 3, 0);
        step(1, -3072, 410, a, b, 17, 0);
      end

    // counter saturation corners (R6)
    step(1, 100, 100, 0, 0, 255, 0);
    step(1, 100, 100, 0, 0, 254, 0);
    step(1, 100, 100, 8000, 8000, 255, 0);
    step(1, 100, 100, 8000, 8000, 255, 1);

    // random tokens with bubbles and pre-escaped tokens (R3, R7)
    for (int i = 0; i < 3000; i++) begin
      int c;
      c = int'(rnd() >> 24);
      if (c < 64) c = 254 + (c & 1);
      step((rnd() % 8) != 0, rsigned(), rsigned(), rsigned() / (1 + int'(rnd() % 3)),
           rsigned() / (1 + int'(rnd() % 3)), c, (rnd() % 4) == 0);
    end

    // drain
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule